// File: doc/BRIEF.md
# Unified Address Translation Lookup with Protection Check

This block turns a 32-bit virtual address into a physical address through a small fully associative table. Each slot carries a virtual page tag, an address-space tag, a page-size code and access rights. A lookup is one request cycle followed one cycle later by a response. The response holds either the translated address or a 12-bit fault code that the core's exception logic uses as its event number. All slots are compared in parallel. Each slot masks the compare to its own page size, from 1 KB up to 1 MB. Two or more matching slots give a dedicated fault.

The block holds the page-table-entry-high state: a virtual page number plus the current address-space tag. Software writes it through a port, and the block rewrites the page number when a translation faults. The block also latches the faulting address. A replacement counter moves forward on every lookup. Software may cap it with a boundary value. The counter picks the slot that the load strobe writes. A loaded slot takes its page tag and address-space tag from the page-table-entry-high state and its remaining fields from the load inputs.

Top module: `tlb_unit`

## Requirements
- R1: After reset, `rspValid` is 0, `replCount` is 0, `ptehOut` is 0 and `faultAddr` is 0. `rspValid` is high in exactly the cycle after a cycle with `reqValid` high, and low otherwise.
- R2: A slot matches an address when the address bits above the page offset equal the tag bits above the page offset. The tag is the stored page number shifted left by 10. Offset widths by size code: 0 gives 10 bits (1 KB), 1 gives 12 (4 KB), 2 gives 16 (64 KB), 3 gives 20 (1 MB).
- R3: On a clean hit, `rspCode` is 0x000. `rspPaddr` is the stored physical page number shifted left by 10, with its offset-width low bits replaced by the virtual address's offset bits. On any fault, `rspPaddr` is 0.
- R4: A slot whose valid bit is 0 never matches.
- R5: The address-space check is skipped when `reqPriv` and `svIgnore` are both 1. Otherwise a non-shared slot matches only if its address-space tag equals `ptehOut[7:0]`. A shared slot ignores the tag.
- R6: Two or more matching slots give code 0x140.
- R7: No matching slot gives code 0x040 for a read and 0x060 for a write (`reqWrite` = 1).
- R8: If `reqPriv` = 0 and protection bit 1 is 0, the code is 0x0A0 for a read and 0x0C0 for a write. In either mode, a write to a slot with protection bit 0 clear gives 0x0C0. These checks come before the dirty check.
- R9: A write that passes the protection checks to a slot whose dirty bit is 0 gives code 0x080.
- R10: `replCount` advances by one on each lookup. It returns to 0 when the advanced value exceeds a nonzero `boundary`, or exceeds 63.
- R11: `loadStrobe` writes the slot chosen by `replCount`. The page and address-space tags come from `ptehOut`; the other fields come from the load inputs. A load does not advance `replCount`.
- R12: On any fault, `faultAddr` takes the request address. Except for code 0x140, `ptehOut[31:10]` takes the request address bits 31:10 and `ptehOut[7:0]` is kept. On code 0x140, `ptehOut` is unchanged.
- R13: `ptehWrite` loads `ptehOut` bits 31:10 and 7:0 from `ptehWrData`. `ptehOut[9:8]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| reqPriv | input | 1 | 1 = privileged mode |
| svIgnore | input | 1 | Skip address-space check in privileged mode |
| rspValid | output | 1 | Response valid, one cycle after request |
| rspCode | output | 12 | Fault code, 0 on clean hit |
| rspPaddr | output | 32 | Translated physical address |
| faultAddr | output | 32 | Last faulting virtual address |
| ptehWrite | input | 1 | Write strobe for page-table-entry-high state |
| ptehWrData | input | 32 | Write data: page number in 31:10, address-space tag in 7:0 |
| ptehOut | output | 32 | Current page-table-entry-high state |
| loadStrobe | input | 1 | Write the counter-selected slot |
| loadValid | input | 1 | Valid bit for the loaded slot |
| loadShared | input | 1 | Shared bit for the loaded slot |
| loadSize | input | 2 | Page size code |
| loadProt | input | 2 | Protection bits (bit 1 user access, bit 0 write) |
| loadDirty | input | 1 | Dirty bit |
| loadPpn | input | 19 | Physical page number |
| boundary | input | 6 | Replacement counter limit, 0 = none |
| replCount | output | 6 | Replacement counter |

## Verification
The bench builds the block with its default of 64 slots. At that size the counter's natural wrap from 63 to 0 is reached by a plain run of lookups, and a boundary set below the current count forces an early wrap. All four page sizes are loaded side by side. Each one is probed at an in-page address with high physical page bits set, which shows the offset merge, and again just past its end. Because the counter picks the load slot, two loads to the same tag separated by one lookup build the multiple-hit case through the ordinary ports.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;
  localparam int ASID_W = 8;

  localparam logic [11:0] CODE_OK    = 12'h000;
  localparam logic [11:0] CODE_RMISS = 12'h040;
  localparam logic [11:0] CODE_WMISS = 12'h060;
  localparam logic [11:0] CODE_INITW = 12'h080;
  localparam logic [11:0] CODE_RPROT = 12'h0A0;
  localparam logic [11:0] CODE_WPROT = 12'h0C0;
  localparam logic [11:0] CODE_MULTI = 12'h140;

  typedef struct packed {
    logic             valid;
    logic             shared;
    logic [1:0]       size;
    logic [1:0]       prot;
    logic             dirty;
    logic [PPN_W-1:0] ppn;
  } tlbData_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    tlbData_t          data;
  } tlbEntry_t;

  typedef struct packed {
    logic load;
    logic asidCheck;
  } tlbStrobe_t;

  typedef struct packed {
    logic        hit;
    logic        multi;
    tlbData_t    data;
    logic [31:0] paddr;
  } tlbResult_t;

  function automatic logic [31:0] pageMask(input logic [1:0] sz);
    case (sz)
      2'd0:    pageMask = 32'h0000_03FF;
      2'd1:    pageMask = 32'h0000_0FFF;
      2'd2:    pageMask = 32'h0000_FFFF;
      default: pageMask = 32'h000F_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [SLOT_W-1:0] slot,
  input  logic [VPN_W-1:0]  tagVpn,
  input  logic [ASID_W-1:0] tagAsid,
  input  tlbData_t          loadData,
  input  logic [31:0]       lookAddr,
  output tlbResult_t        res
);
  tlbEntry_t          entries [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  tlbData_t           selData;
  logic [31:0]        selMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) entries[i] <= '0;
    end else if (strobe.load) begin
      entries[slot] <= '{vpn: tagVpn, asid: tagAsid, data: loadData};
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    logic [31:0] baseAddr;
    logic [31:0] offMask;
    logic        asidOk;
    always_comb begin
      baseAddr    = {entries[g].vpn, 10'b0};
      offMask     = pageMask(entries[g].data.size);
      asidOk      = entries[g].data.shared || !strobe.asidCheck ||
                    (entries[g].asid == tagAsid);
      matchVec[g] = entries[g].data.valid && asidOk &&
                    (((lookAddr ^ baseAddr) & ~offMask) == 32'h0);
    end
  end

  always_comb begin
    selData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) selData = selData | entries[i].data;
    end
    selMask   = pageMask(selData.size);
    res.hit   = |matchVec;
    res.multi = |(matchVec & (matchVec - ENTRIES'(1)));
    res.data  = selData;
    res.paddr = ({3'b0, selData.ppn, 10'b0} & ~selMask) | (lookAddr & selMask);
  end

  AST_LOAD_STORES_TAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> entries[$past(slot)].vpn == $past(tagVpn)); // R11
  AST_INVALID_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !entries[0].data.valid |-> !matchVec[0]); // R4
endmodule

// File: rtl/tlb_lookup_ctrl.sv
module tlb_lookup_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic              svIgnore,
  input  logic              ptehWrite,
  input  logic [31:0]       ptehWrData,
  input  logic              loadStrobe,
  input  logic [SLOT_W-1:0] boundary,
  input  tlbResult_t        res,
  output tlbStrobe_t        strobe,
  output logic [SLOT_W-1:0] cnt,
  output logic [VPN_W-1:0]  ptehVpn,
  output logic [ASID_W-1:0] ptehAsid,
  output logic              rspValid,
  output logic [11:0]       rspCode,
  output logic [31:0]       rspPaddr,
  output logic [31:0]       faultAddr
);
  localparam logic [SLOT_W:0] LAST = (SLOT_W + 1)'(ENTRIES - 1);

  logic [11:0]     code;
  logic [SLOT_W:0] cntInc;
  logic            cntWrap;

  always_comb begin
    strobe.load      = loadStrobe;
    strobe.asidCheck = !(reqPriv && svIgnore);
  end

  always_comb begin
    code = CODE_OK;
    if (res.multi)                             code = CODE_MULTI;
    else if (!res.hit)                         code = reqWrite ? CODE_WMISS : CODE_RMISS;
    else if (!reqPriv && !res.data.prot[1])    code = reqWrite ? CODE_WPROT : CODE_RPROT;
    else if (reqWrite && !res.data.prot[0])    code = CODE_WPROT;
    else if (reqWrite && !res.data.dirty)      code = CODE_INITW;
  end

  always_comb begin
    cntInc  = {1'b0, cnt} + 1'b1;
    cntWrap = ((boundary != '0) && (cntInc > {1'b0, boundary})) || (cntInc > LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      ptehVpn   <= '0;
      ptehAsid  <= '0;
      rspValid  <= 1'b0;
      rspCode   <= CODE_OK;
      rspPaddr  <= '0;
      faultAddr <= '0;
    end else begin
      rspValid <= reqValid;
      if (ptehWrite) begin
        ptehVpn  <= ptehWrData[31:10];
        ptehAsid <= ptehWrData[7:0];
      end
      if (reqValid) begin
        rspCode  <= code;
        rspPaddr <= (code == CODE_OK) ? res.paddr : 32'h0;
        cnt      <= cntWrap ? '0 : cntInc[SLOT_W-1:0];
        if (code != CODE_OK) begin
          faultAddr <= reqAddr;
          if (code != CODE_MULTI) ptehVpn <= reqAddr[31:10];
        end
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R1
  AST_OK_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (code == CODE_OK) |=> rspPaddr[9:0] == $past(reqAddr[9:0])); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (cnt < boundary) |=> cnt == $past(cnt) + 1'b1); // R10
  AST_CNT_BOUND_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (boundary != '0) && (cnt >= boundary) |=> cnt == '0); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(cnt)); // R11
  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspCode != CODE_OK) |-> faultAddr == $past(reqAddr)); // R12
  AST_MULTI_KEEPS_PTEH: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspCode == CODE_MULTI) && !$past(ptehWrite) |->
      ptehVpn == $past(ptehVpn)); // R12
endmodule

// File: rtl/tlb_unit.sv
module tlb_unit
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic              svIgnore,
  output logic              rspValid,
  output logic [11:0]       rspCode,
  output logic [31:0]       rspPaddr,
  output logic [31:0]       faultAddr,
  input  logic              ptehWrite,
  input  logic [31:0]       ptehWrData,
  output logic [31:0]       ptehOut,
  input  logic              loadStrobe,
  input  logic              loadValid,
  input  logic              loadShared,
  input  logic [1:0]        loadSize,
  input  logic [1:0]        loadProt,
  input  logic              loadDirty,
  input  logic [PPN_W-1:0]  loadPpn,
  input  logic [SLOT_W-1:0] boundary,
  output logic [SLOT_W-1:0] replCount
);
  tlbStrobe_t        strobe;
  tlbResult_t        res;
  tlbData_t          loadData;
  logic [VPN_W-1:0]  ptehVpn;
  logic [ASID_W-1:0] ptehAsid;

  assign loadData = '{valid: loadValid, shared: loadShared, size: loadSize,
                      prot: loadProt, dirty: loadDirty, ppn: loadPpn};
  assign ptehOut  = {ptehVpn, 2'b00, ptehAsid};

  tlb_entry_array #(.ENTRIES(ENTRIES)) array_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(replCount),
    .tagVpn(ptehVpn), .tagAsid(ptehAsid), .loadData(loadData),
    .lookAddr(reqAddr), .res(res)
  );

  tlb_lookup_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqPriv(reqPriv), .svIgnore(svIgnore),
    .ptehWrite(ptehWrite), .ptehWrData(ptehWrData), .loadStrobe(loadStrobe),
    .boundary(boundary), .res(res), .strobe(strobe), .cnt(replCount),
    .ptehVpn(ptehVpn), .ptehAsid(ptehAsid), .rspValid(rspValid),
    .rspCode(rspCode), .rspPaddr(rspPaddr), .faultAddr(faultAddr)
  );
endmodule

// File: tb/tlb_unit_tb.sv
module tlb_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqWrite = 0, reqPriv = 0, svIgnore = 0;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic [11:0] rspCode;
  logic [31:0] rspPaddr, faultAddr, ptehOut;
  logic        ptehWrite = 0;
  logic [31:0] ptehWrData = '0;
  logic        loadStrobe = 0, loadValid = 0, loadShared = 0, loadDirty = 0;
  logic [1:0]  loadSize = '0, loadProt = '0;
  logic [18:0] loadPpn = '0;
  logic [5:0]  boundary = '0;
  logic [5:0]  replCount;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0]  mCnt = '0;
  logic [5:0]  mBound = '0;
  logic [31:0] mPteh = '0;

  always #5 clk = ~clk;

  tlb_unit dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] paOf(input logic [18:0] ppn, input logic [1:0] sz,
                                       input logic [31:0] va);
    logic [31:0] m;
    case (sz)
      2'd0: m = 32'h3FF;  2'd1: m = 32'hFFF;
      2'd2: m = 32'hFFFF; default: m = 32'hFFFFF;
    endcase
    return ((32'(ppn) << 10) & ~m) | (va & m);
  endfunction

  task automatic setPteh(input logic [31:0] v);
    @(negedge clk); ptehWrite = 1; ptehWrData = v;
    @(negedge clk); ptehWrite = 0;
    mPteh = {v[31:10], 2'b00, v[7:0]};
    chk("R13 pteh write", ptehOut, mPteh);
  endtask

  task automatic doLook(input logic [31:0] va, input logic wr, input logic priv,
                        input logic svi, input logic [11:0] expCode,
                        input logic [31:0] expPa, input string req);
    logic [5:0] inc;
    @(negedge clk);
    reqValid = 1; reqAddr = va; reqWrite = wr; reqPriv = priv; svIgnore = svi;
    @(negedge clk);
    reqValid = 0;
    chk("R1 rspValid", 32'(rspValid), 32'd1);
    chk({req, " code"}, 32'(rspCode), 32'(expCode));
    chk({req, " paddr"}, rspPaddr, (expCode == 12'h0) ? expPa : 32'h0);
    inc = mCnt + 6'd1;
    if ((mBound != 0 && inc > mBound) || mCnt == 6'd63) inc = '0;
    mCnt = inc;
    chk("R10 counter", 32'(replCount), 32'(mCnt));
    if (expCode != 12'h0) begin
      chk("R12 faultAddr", faultAddr, va);
      if (expCode != 12'h140) mPteh = {va[31:10], 2'b00, mPteh[7:0]};
    end
    chk("R12 pteh", ptehOut, mPteh);
    @(negedge clk);
    chk("R1 rspValid idle", 32'(rspValid), 32'd0);
  endtask

  task automatic loadAt(input logic [31:0] pteh, input logic v, input logic sh,
                        input logic [1:0] sz, input logic [1:0] pr, input logic d,
                        input logic [18:0] ppn);
    setPteh(pteh);
    @(negedge clk);
    loadStrobe = 1; loadValid = v; loadShared = sh; loadSize = sz;
    loadProt = pr; loadDirty = d; loadPpn = ppn;
    @(negedge clk); loadStrobe = 0;
    chk("R11 load keeps counter", 32'(replCount), 32'(mCnt));
    doLook(32'hFFFF_F000, 0, 1, 0, 12'h040, 0, "R7 step miss");
  endtask

  task automatic tReset();
    chk("R1 reset rspValid", 32'(rspValid), 0);
    chk("R1 reset counter", 32'(replCount), 0);
    chk("R1 reset pteh", ptehOut, 0);
    chk("R1 reset faultAddr", faultAddr, 0);
  endtask

  task automatic tMiss();
    setPteh(32'h0000_0033);
    doLook(32'hABCD_E123, 0, 0, 0, 12'h040, 0, "R7 read miss");
    chk("R12 pteh vpn+asid", ptehOut, 32'hABCD_E033);
    doLook(32'h0000_1000, 1, 0, 0, 12'h060, 0, "R7 write miss");
  endtask

  task automatic tSizes();
    for (int s = 0; s < 4; s++) begin
      logic [31:0] base, va, span;
      logic [18:0] ppn;
      base = 32'h1000_0000 * (s + 1);
      ppn  = 19'h7FFF0 | 19'(s);
      span = (s == 0) ? 32'h400 : (s == 1) ? 32'h1000 : (s == 2) ? 32'h10000 : 32'h100000;
      loadAt(base | 32'h33, 1, 0, 2'(s), 2'b11, 1, ppn);
      va = base | (32'h000A_BCDE & (span - 1));
      doLook(va, 0, 0, 0, 12'h0, paOf(ppn, 2'(s), va), "R2 R3 size hit");
      doLook(base + span, 0, 0, 0, 12'h040, 0, "R2 past page end");
    end
  endtask

  task automatic tAsid();
    loadAt(32'h5000_0005, 1, 0, 2'd1, 2'b11, 1, 19'h00111);
    loadAt(32'h5800_0009, 1, 1, 2'd1, 2'b11, 1, 19'h00222);
    setPteh(32'h0000_0006);
    doLook(32'h5000_0010, 0, 0, 0, 12'h040, 0, "R5 asid mismatch user");
    doLook(32'h5000_0010, 0, 1, 0, 12'h040, 0, "R5 asid mismatch priv");
    doLook(32'h5000_0010, 0, 1, 1, 12'h0, paOf(19'h00111, 1, 32'h5000_0010), "R5 ignore in priv");
    doLook(32'h5000_0010, 0, 0, 1, 12'h040, 0, "R5 ignore needs priv");
    doLook(32'h5800_0010, 0, 0, 0, 12'h0, paOf(19'h00222, 1, 32'h5800_0010), "R5 shared");
  endtask

  task automatic tValid();
    loadAt(32'h6000_0006, 0, 1, 2'd3, 2'b11, 1, 19'h00333);
    doLook(32'h6000_0040, 0, 1, 1, 12'h040, 0, "R4 invalid slot");
  endtask

  task automatic tMulti();
    loadAt(32'h7000_0006, 1, 0, 2'd1, 2'b11, 1, 19'h00444);
    loadAt(32'h7000_0006, 1, 0, 2'd0, 2'b11, 1, 19'h00555);
    setPteh(32'h1234_5406);
    doLook(32'h7000_0004, 0, 0, 0, 12'h140, 0, "R6 multi hit");
    chk("R12 multi keeps pteh", ptehOut, 32'h1234_5406);
  endtask

  task automatic tProt();
    loadAt(32'h9000_0006, 1, 0, 2'd1, 2'b00, 1, 19'h00A00);
    loadAt(32'h9100_0006, 1, 0, 2'd1, 2'b10, 0, 19'h00B00);
    loadAt(32'h9200_0006, 1, 0, 2'd1, 2'b11, 0, 19'h00C00);
    loadAt(32'h9300_0006, 1, 0, 2'd1, 2'b01, 1, 19'h00D00);
    doLook(32'h9000_0008, 0, 0, 0, 12'h0A0, 0, "R8 user read no access");
    doLook(32'h9000_0008, 1, 0, 0, 12'h0C0, 0, "R8 user write no access");
    doLook(32'h9000_0008, 0, 1, 0, 12'h0, paOf(19'h00A00, 1, 32'h9000_0008), "R8 priv read ok");
    doLook(32'h9000_0008, 1, 1, 0, 12'h0C0, 0, "R8 priv write read-only");
    doLook(32'h9100_0008, 1, 0, 0, 12'h0C0, 0, "R8 before dirty");
    doLook(32'h9200_0008, 1, 0, 0, 12'h080, 0, "R9 initial write");
    doLook(32'h9200_0008, 0, 0, 0, 12'h0, paOf(19'h00C00, 1, 32'h9200_0008), "R9 read clean ok");
    doLook(32'h9300_0008, 0, 0, 0, 12'h0A0, 0, "R8 user bit clear");
    doLook(32'h9300_0008, 1, 1, 0, 12'h0, paOf(19'h00D00, 1, 32'h9300_0008), "R8 priv write ok");
  endtask

  task automatic tCounter();
    @(negedge clk); boundary = 6'd3; mBound = 6'd3;
    for (int i = 0; i < 5; i++) doLook(32'hFFFF_F000, 0, 1, 0, 12'h040, 0, "R10 bounded");
    @(negedge clk); boundary = 6'd0; mBound = 6'd0;
    for (int i = 0; i < 66; i++) doLook(32'hFFFF_F000, 0, 1, 0, 12'h040, 0, "R10 full wrap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    tMiss();
    tSizes();
    tAsid();
    tValid();
    tMulti();
    tProt();
    tCounter();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule